// File: doc/BRIEF.md
# ULPI Register Viewport Controller

This block gives host software one 32-bit command and status word through which it can read and write the registers of an external ULPI transceiver. Software writes the word with the run bit set. The controller then performs one register access on the ULPI link, using the 8-bit data bus and the dir, nxt and stp lines. When the access ends, the controller clears the run bit itself. For a read, it places the returned byte in the word. Software polls the word until the run bit reads zero.

A separate wakeup bit asks the controller to pull a suspended link back into synchronous operation. A read-only sync flag reports when that has happened. Every busy bit is cleared in bounded time. If the transceiver never answers, an internal timeout ends the wakeup or the access, so software polling always terminates.

Top module: `ulpi_view_ctrl`

## Requirements
- R1: After reset the whole word reads zero, the sync flag (bit 27) is low, and the link bus is neither driven nor stopped.
- R2: Setting bit 31 (wakeup) makes the controller hold stp high while dir is high. Once dir is seen low, bit 31 clears and bit 27 (sync) becomes 1, and sync stays 1 from then on.
- R3: A write with bit 30 (run) set starts one access. Bit 30 reads 1 until the access ends, then 0. The word reads back as: bit 29 direction (1 = write), bit 28 zero, bits 26:24 port select, bits 23:16 register address, bits 15:8 read data, bits 7:0 write data. Bits 27 and 15:8 of a software write are ignored.
- R4: A register write drives the byte {2'b10, addr[5:0]} until nxt is high, then the data byte until nxt is high, then raises stp for exactly one cycle. The transceiver register takes the data.
- R5: A register read drives {2'b11, addr[5:0]} until nxt is high, then leaves the bus for one turnaround cycle. It captures the input byte on the next cycle and waits for dir to fall. Only bits 15:8 take the captured byte; bits 7:0 keep their value. Bits 15:8 change at no other time.
- R6: If dir rises while the command byte is being driven, the command is abandoned and sent again after dir falls. Bit 30 stays 1 throughout.
- R7: Software writes are ignored while bit 30 or bit 31 reads 1.
- R8: When one write sets both bit 31 and bit 30, the access starts only after the wakeup has finished and bit 31 reads 0.
- R9: Bit 31 and bit 30 each clear within TIMEOUT_CYCLES cycles, even if the link never responds. A timed-out access leaves bits 15:8 unchanged. A timed-out wakeup leaves sync unchanged.
- R10: The controller never drives the data bus while dir is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; all logic on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| view_wr | input | 1 | Write strobe for the viewport word |
| view_wdata | input | 32 | Value written to the viewport word |
| view_rdata | output | 32 | Current viewport word |
| ulpi_dir | input | 1 | Bus direction from the transceiver (1 = transceiver drives) |
| ulpi_nxt | input | 1 | Transceiver throttle/acknowledge |
| ulpi_din | input | 8 | Data bus as driven by the transceiver |
| ulpi_dout | output | 8 | Data bus value driven by the controller |
| ulpi_oe | output | 1 | Controller drives the data bus when 1 |
| ulpi_stp | output | 1 | Stop line to the transceiver |

## Verification
A wakeup and an access can both be pending after one write. This case is provoked by putting the modelled transceiver into low power (dir held high) and then writing bits 31 and 30 together. The transceiver model records the word as seen at the port when the first command byte reaches it, and the bench requires bit 31 to read 0 at that moment. It also requires the access to land in the transceiver register afterwards. Random accesses with injected aborts, variable nxt delays and variable dir hold times are mixed in, and every completed word is compared with a value the bench builds from the fields it wrote.

// File: rtl/ulpi_vp_pkg.sv
package ulpi_vp_pkg;
  localparam int VIEW_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int PORT_W   = 3;
  localparam int REGA_W   = 6;
  localparam int BIT_WAKE = 31;
  localparam int BIT_RUN  = 30;
  localparam int BIT_DIRW = 29;
  localparam int PORT_LSB = 24;
  localparam int ADDR_LSB = 16;
  localparam int WD_LSB   = 0;
  localparam logic [1:0] OP_WRITE = 2'b10;
  localparam logic [1:0] OP_READ  = 2'b11;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_CMD, SQ_WDATA, SQ_STOP, SQ_TURN, SQ_RDCAP, SQ_RDEND, SQ_DONE
  } seq_state_t;
endpackage

// File: rtl/ulpi_vp_timer.sv
module ulpi_vp_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt_q;

  assign expired = active && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !active || expired) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(LIMIT));
endmodule

// File: rtl/ulpi_vp_wake.sv
module ulpi_vp_wake #(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_req,
  input  logic dir,
  output logic stp,
  output logic done,
  output logic sync
);
  logic busy, tmo;

  assign busy = wake_req && !done;

  ulpi_vp_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .active(busy), .expired(tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stp  <= 1'b0;
      done <= 1'b0;
      sync <= 1'b0;
    end else begin
      stp  <= 1'b0;
      done <= 1'b0;
      if (busy) begin
        if (!dir) begin
          done <= 1'b1;
          sync <= 1'b1;
        end else if (tmo) begin
          done <= 1'b1;
        end else begin
          stp <= 1'b1;
        end
      end
    end
  end

  assert_sync_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    sync |=> sync);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/ulpi_vp_seq.sv
module ulpi_vp_seq
  import ulpi_vp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_op,
  input  logic [REGA_W-1:0] addr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              dir,
  input  logic              nxt,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              oe,
  output logic              stp,
  output logic              done,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_byte
);
  seq_state_t state_q, state_n;
  logic tmo;

  ulpi_vp_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .active(start && (state_q != SQ_DONE)), .expired(tmo)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      SQ_IDLE:  if (start && !dir) state_n = SQ_CMD;
      SQ_CMD:   if (dir) state_n = SQ_IDLE;
                else if (nxt) state_n = wr_op ? SQ_WDATA : SQ_TURN;
      SQ_WDATA: if (dir) state_n = SQ_IDLE;
                else if (nxt) state_n = SQ_STOP;
      SQ_STOP:  state_n = SQ_DONE;
      SQ_TURN:  state_n = SQ_RDCAP;
      SQ_RDCAP: state_n = dir ? SQ_RDEND : SQ_IDLE;
      SQ_RDEND: if (!dir) state_n = SQ_DONE;
      SQ_DONE:  state_n = SQ_IDLE;
      default:  state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      rd_byte <= '0;
    end else begin
      state_q <= tmo ? SQ_IDLE : state_n;
      if (state_q == SQ_RDCAP && dir) rd_byte <= din;
    end
  end

  always_comb begin
    unique case (state_q)
      SQ_CMD:   dout = {wr_op ? OP_WRITE : OP_READ, addr};
      SQ_WDATA: dout = wbyte;
      default:  dout = '0;
    endcase
  end

  assign oe       = !dir && (state_q == SQ_CMD || state_q == SQ_WDATA || state_q == SQ_STOP);
  assign stp      = (state_q == SQ_STOP);
  assign done     = (state_q == SQ_DONE) || tmo;
  assign rd_valid = (state_q == SQ_DONE) && !wr_op;

  assert_stp_single_R4: assert property (@(posedge clk) disable iff (rst)
    stp |=> !stp);
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_CMD && !nxt && !dir && !tmo) |=> (state_q == SQ_CMD));
  assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_CMD && dir && !tmo) |=> (state_q == SQ_IDLE));
endmodule

// File: rtl/ulpi_vp_regs.sv
module ulpi_vp_regs
  import ulpi_vp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [VIEW_W-1:0] wdata,
  input  logic              wake_done,
  input  logic              seq_done,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic              sync,
  output logic [VIEW_W-1:0] rdata,
  output logic              wake_q,
  output logic              run_q,
  output logic              wr_q,
  output logic [REGA_W-1:0] op_addr,
  output logic [BYTE_W-1:0] wbyte_q
);
  logic [PORT_W-1:0] port_q;
  logic [BYTE_W-1:0] addr_q, rbyte_q;
  logic accept;
  logic unused_bits;

  assign accept      = wr_en && !run_q && !wake_q;
  assign unused_bits = ^{wdata[28:27], wdata[15:8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q  <= 1'b0;
      run_q   <= 1'b0;
      wr_q    <= 1'b0;
      port_q  <= '0;
      addr_q  <= '0;
      rbyte_q <= '0;
      wbyte_q <= '0;
    end else begin
      if (accept) begin
        wake_q  <= wdata[BIT_WAKE];
        run_q   <= wdata[BIT_RUN];
        wr_q    <= wdata[BIT_DIRW];
        port_q  <= wdata[PORT_LSB +: PORT_W];
        addr_q  <= wdata[ADDR_LSB +: BYTE_W];
        wbyte_q <= wdata[WD_LSB +: BYTE_W];
      end
      if (wake_done) wake_q <= 1'b0;
      if (seq_done) begin
        run_q <= 1'b0;
        if (rd_valid) rbyte_q <= rd_byte;
      end
    end
  end

  assign op_addr = addr_q[REGA_W-1:0];
  assign rdata   = {wake_q, run_q, wr_q, 1'b0, sync, port_q, addr_q, rbyte_q, wbyte_q};

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && run_q) |=> ($stable(addr_q) && $stable(wbyte_q) && $stable(wr_q) && $stable(port_q)));
  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(seq_done && rd_valid) |=> $stable(rbyte_q));
endmodule

// File: rtl/ulpi_view_ctrl.sv
module ulpi_view_ctrl
  import ulpi_vp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        view_wr,
  input  logic [31:0] view_wdata,
  output logic [31:0] view_rdata,
  input  logic        ulpi_dir,
  input  logic        ulpi_nxt,
  input  logic [7:0]  ulpi_din,
  output logic [7:0]  ulpi_dout,
  output logic        ulpi_oe,
  output logic        ulpi_stp
);
  logic wake_q, run_q, wr_q, wake_done, wake_stp, sync;
  logic seq_done, seq_stp, rd_valid;
  logic [REGA_W-1:0] op_addr;
  logic [BYTE_W-1:0] wbyte, rd_byte;

  ulpi_vp_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(view_wr), .wdata(view_wdata),
    .wake_done(wake_done), .seq_done(seq_done), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .sync(sync), .rdata(view_rdata),
    .wake_q(wake_q), .run_q(run_q), .wr_q(wr_q), .op_addr(op_addr), .wbyte_q(wbyte)
  );

  ulpi_vp_wake #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_wake (
    .clk(clk), .rst(rst), .wake_req(wake_q), .dir(ulpi_dir),
    .stp(wake_stp), .done(wake_done), .sync(sync)
  );

  ulpi_vp_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(run_q && !wake_q), .wr_op(wr_q),
    .addr(op_addr), .wbyte(wbyte), .dir(ulpi_dir), .nxt(ulpi_nxt), .din(ulpi_din),
    .dout(ulpi_dout), .oe(ulpi_oe), .stp(seq_stp), .done(seq_done),
    .rd_valid(rd_valid), .rd_byte(rd_byte)
  );

  assign ulpi_stp = wake_stp | seq_stp;

  assert_wake_first_R8: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> !ulpi_oe);
  assert_seq_quiet_on_wake_R8: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> !seq_stp);
endmodule

// File: tb/ulpi_view_ctrl_test.sv
module ulpi_view_ctrl_test;
  localparam int TMO = 200;
  localparam int P_IDLE = 0, P_CMDW = 1, P_DATAW = 2, P_DATAC = 3,
                 P_RTURN = 4, P_RDATA = 5, P_RHOLD = 6, P_ABORT = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic view_wr = 1'b0;
  logic [31:0] view_wdata = '0, view_rdata;
  logic dir = 1'b0, nxt = 1'b0;
  logic [7:0] din = '0, dout;
  logic oe, stp;

  always #10 clk = ~clk;

  ulpi_view_ctrl #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk(clk), .rst(rst), .view_wr(view_wr), .view_wdata(view_wdata),
    .view_rdata(view_rdata), .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_din(din),
    .ulpi_dout(dout), .ulpi_oe(oe), .ulpi_stp(stp)
  );

  int checks = 0, fails = 0;
  logic [7:0] preg [64];
  logic [7:0] emem [64];
  bit lp = 1'b1, lp_stuck = 1'b0, mute = 1'b0, abort_next = 1'b0;
  int nxt_wait = 0, data_wait = 0, rd_hold = 0;
  int ps = P_IDLE, w = 0, w2 = 0;
  int cmd_count = 0, stp_missing = 0, drive_viol = 0;
  logic [7:0] last_cmd = '0, last_wdat = '0;
  logic wu_at_cmd = 1'b0;
  logic [5:0] cur_a = '0;
  bit cur_w = 1'b0;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] cmd_word(input bit wu, input bit run, input bit wr,
      input logic [2:0] port, input logic [7:0] addr, input logic [7:0] wd,
      input logic [7:0] junk);
    return {wu, run, wr, 1'b1, 1'b1, port, addr, junk, wd};
  endfunction

  function automatic logic [31:0] exp_view(input bit wr, input bit sync,
      input logic [2:0] port, input logic [7:0] addr, input logic [7:0] rd,
      input logic [7:0] wd);
    return {1'b0, 1'b0, wr, 1'b0, sync, port, addr, rd, wd};
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic vw(input logic [31:0] v);
    @(negedge clk);
    view_wr = 1'b1;
    view_wdata = v;
    @(negedge clk);
    view_wr = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while ((view_rdata[31] || view_rdata[30]) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // transceiver model
  always @(negedge clk) begin
    if (rst) begin
      ps = P_IDLE; dir = 1'b0; nxt = 1'b0; din = '0;
    end else begin
      if (dir && oe) drive_viol++;
      if (lp) begin
        dir = 1'b1; nxt = 1'b0;
        if (stp && !lp_stuck) begin lp = 1'b0; dir = 1'b0; end
      end else begin
        case (ps)
          P_IDLE: begin
            nxt = 1'b0;
            if (oe && dout[7]) begin
              cmd_count++;
              last_cmd = dout;
              wu_at_cmd = view_rdata[31];
              cur_a = dout[5:0];
              cur_w = !dout[6];
              w2 = data_wait;
              if (abort_next) begin
                abort_next = 1'b0; dir = 1'b1; w = 2; ps = P_ABORT;
              end else if (!mute) begin
                if (nxt_wait == 0) begin
                  nxt = 1'b1; ps = cur_w ? P_DATAW : P_RTURN;
                end else begin
                  w = nxt_wait; ps = P_CMDW;
                end
              end
            end
          end
          P_CMDW: begin
            w--;
            if (w == 0) begin nxt = 1'b1; ps = cur_w ? P_DATAW : P_RTURN; end
          end
          P_DATAW: begin
            if (w2 > 0) begin nxt = 1'b0; w2--; end
            else begin nxt = 1'b1; last_wdat = dout; ps = P_DATAC; end
          end
          P_DATAC: begin
            nxt = 1'b0;
            if (stp) preg[cur_a] = last_wdat;
            else stp_missing++;
            ps = P_IDLE;
          end
          P_RTURN: begin nxt = 1'b0; dir = 1'b1; ps = P_RDATA; end
          P_RDATA: begin din = preg[cur_a]; w = rd_hold; ps = P_RHOLD; end
          P_RHOLD: begin
            din = ~preg[cur_a];
            if (w == 0) begin dir = 1'b0; ps = P_IDLE; end
            else w--;
          end
          P_ABORT: begin
            w--;
            if (w == 0) begin dir = 1'b0; ps = P_IDLE; end
          end
          default: ps = P_IDLE;
        endcase
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, c0;
    logic [7:0] exp_rd;
    logic [7:0] e;
    int unsigned seed;
    for (int i = 0; i < 64; i++) begin preg[i] = init_val(i); emem[i] = init_val(i); end
    exp_rd = '0;
    seed = $urandom(32'd7719);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check32("R1 reset word", view_rdata, 32'h0);
    check32("R1 reset bus", {30'h0, oe, stp}, 32'h0);

    // wakeup with a transceiver that never leaves low power
    lp_stuck = 1'b1;
    vw(32'h8000_0000);
    @(negedge clk);
    check32("R2 stp while dir high", {31'h0, stp}, 32'h1);
    vw(cmd_word(0, 1, 1, 3'd1, 8'h3F, 8'h42, 8'h00));
    wait_done(n);
    check32("R9 wake timeout clears bit31", view_rdata, 32'h0);
    check32("R9 wake not early", (n >= TMO / 2) ? 32'h1 : 32'h0, 32'h1);
    check32("R7 write ignored during wakeup", {24'h0, preg[6'h3F]}, {24'h0, init_val(63)});

    // proper wakeup
    lp_stuck = 1'b0;
    vw(32'h8000_0000);
    wait_done(n);
    check32("R2 wake done", view_rdata, exp_view(0, 1, 3'd0, 8'h00, 8'h00, 8'h00));
    check32("R2 link left low power", {31'h0, lp}, 32'h0);

    // directed write
    nxt_wait = 2; data_wait = 1;
    vw(cmd_word(0, 1, 1, 3'd5, 8'hC7, 8'hA5, 8'hFF));
    wait_done(n);
    emem[7] = 8'hA5;
    check32("R4 write command byte", {24'h0, last_cmd}, 32'h87);
    check32("R4 register written", {24'h0, preg[7]}, 32'hA5);
    check32("R4 stp after data", stp_missing, 0);
    check32("R3 readback after write", view_rdata, exp_view(1, 1, 3'd5, 8'hC7, exp_rd, 8'hA5));

    // directed read
    nxt_wait = 0; rd_hold = 2;
    vw(cmd_word(0, 1, 0, 3'd2, 8'h12, 8'h77, 8'h5A));
    wait_done(n);
    exp_rd = emem[6'h12];
    check32("R5 read command byte", {24'h0, last_cmd}, 32'hD2);
    check32("R5 read data and kept write byte", view_rdata, exp_view(0, 1, 3'd2, 8'h12, exp_rd, 8'h77));

    // write while busy is ignored
    nxt_wait = 15; c0 = cmd_count;
    vw(cmd_word(0, 1, 0, 3'd3, 8'h20, 8'h11, 8'h00));
    repeat (3) @(negedge clk);
    vw(cmd_word(0, 1, 1, 3'd6, 8'h30, 8'h99, 8'h00));
    wait_done(n);
    exp_rd = emem[6'h20];
    check32("R7 first access kept", view_rdata, exp_view(0, 1, 3'd3, 8'h20, exp_rd, 8'h11));
    check32("R7 second access dropped", {24'h0, preg[6'h30]}, {24'h0, init_val(48)});
    check32("R7 one command only", cmd_count - c0, 1);

    // abort and retry
    nxt_wait = 0; abort_next = 1'b1; c0 = cmd_count;
    vw(cmd_word(0, 1, 1, 3'd0, 8'h09, 8'h3E, 8'h00));
    @(negedge clk);
    @(negedge clk);
    check32("R6 run held during abort", {31'h0, view_rdata[30]}, 32'h1);
    wait_done(n);
    emem[9] = 8'h3E;
    check32("R6 command resent", cmd_count - c0, 2);
    check32("R6 write landed", {24'h0, preg[9]}, 32'h3E);

    // wakeup and run in the same write
    @(negedge clk);
    lp = 1'b1;
    @(negedge clk);
    vw(cmd_word(1, 1, 1, 3'd4, 8'h0A, 8'h5C, 8'h00));
    wait_done(n);
    emem[10] = 8'h5C;
    check32("R8 wake finished before command", {31'h0, wu_at_cmd}, 32'h0);
    check32("R8 access after wake", {24'h0, preg[10]}, 32'h5C);
    check32("R8 final word", view_rdata, exp_view(1, 1, 3'd4, 8'h0A, exp_rd, 8'h5C));

    // access with a silent transceiver
    mute = 1'b1;
    vw(cmd_word(0, 1, 0, 3'd1, 8'h15, 8'h01, 8'h00));
    wait_done(n);
    mute = 1'b0;
    check32("R9 run timeout keeps read data", view_rdata, exp_view(0, 1, 3'd1, 8'h15, exp_rd, 8'h01));
    check32("R9 run not early", (n >= TMO / 2) ? 32'h1 : 32'h0, 32'h1);
    repeat (3) @(negedge clk);

    // random accesses
    for (int k = 0; k < 40; k++) begin
      bit wr;
      logic [7:0] a, wd, junk;
      logic [2:0] pt;
      wr = 1'($urandom % 2);
      a = 8'($urandom); wd = 8'($urandom); junk = 8'($urandom); pt = 3'($urandom);
      nxt_wait = int'($urandom % 4); data_wait = int'($urandom % 3);
      rd_hold = int'($urandom % 3); abort_next = (($urandom % 6) == 0);
      vw(cmd_word(0, 1, wr, pt, a, wd, junk));
      wait_done(n);
      if (wr) emem[a[5:0]] = wd;
      else exp_rd = emem[a[5:0]];
      check32("R3 random word", view_rdata, exp_view(wr, 1, pt, a, exp_rd, wd));
      check32("R4 R5 random command", {24'h0, last_cmd}, {24'h0, wr ? 2'b10 : 2'b11, a[5:0]});
    end
    e = 8'h0;
    for (int i = 0; i < 64; i++) if (preg[i] !== emem[i]) e = e + 8'h1;
    check32("R4 register image", {24'h0, e}, 32'h0);
    check32("R10 no drive while dir high", drive_viol, 0);
    check32("R4 stp count", stp_missing, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule